// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block runs erase operations on a page-organised serial flash memory through a byte-level SPI master. A client presents one request: an erase kind (page, block, sector or whole device), a 24-bit device address and a byte length. The sequencer first checks the request. If it is acceptable, the sequencer sends a four-byte erase command inside one chip-select period. It then reads the device status register again and again until the device reports ready, or until the retry budget for that erase kind runs out.

The SPI shifter sits outside this block. Each byte is exchanged over a simple handshake. The sequencer raises `spi_go` with the byte on `spi_txd` and holds both until the shifter returns `spi_done` for one cycle, with the byte received in `spi_rxd`. `spi_sel` frames each transfer.

The wait between status reads is counted in units of 100 µs. A parameter gives the number of clock cycles per unit.

Top module: `flash_erase_seq`

## Requirements
- R1: The erase opcode follows `req_kind`: 0 = page → 0x81, 1 = block → 0x50, 2 = sector → 0x7C, 3 = whole device → 0xC7.
- R2: An accepted request produces one select period of exactly four bytes: the opcode, then address bits 23:16, then 15:8, then 7:0. While `spi_go` waits for `spi_done`, `spi_txd` holds steady.
- R3: A whole-device erase sends the fixed address bytes 0x94, 0x80, 0x9A, whatever `req_addr` holds.
- R4: After the command, `spi_sel` is low for exactly one cycle. Then the first status read starts. Each status read is its own select period of two bytes: 0xD7, then a dummy 0x00. Only bit 7 of the second returned byte decides readiness (1 = ready). Bits 6:0 have no effect.
- R5: A device that is ready at the first status read completes with `erase_done` and no wait interval.
- R6: Between two status reads, `spi_sel` stays low for exactly `units × TICK_CYCLES` cycles. The units are 5 for page, 10 for block, 2000 for sector and 5000 for whole device.
- R7: The retry budget is 200 for page, 300 for block, 100 for sector and 200 for whole device. A device still busy at read number budget+1 ends the operation with `erase_timeout`. Ready at that last read still gives `erase_done`.
- R8: For page, block and sector kinds, a request whose address or length is not a multiple of `PAGE_BYTES` is rejected with `erase_reject` and no select activity. Whole-device requests skip this alignment check.
- R9: A request with address + length greater than `CAP_BYTES` is rejected the same way, for every kind. An end equal to `CAP_BYTES` is accepted.
- R10: `req_ready` is high only while the block is idle. Every accepted request yields exactly one single-cycle pulse on one of `erase_done`, `erase_timeout` or `erase_reject`, and `req_ready` returns the next cycle.
- R11: After reset, `spi_sel` and `spi_go` are low, `req_ready` is high and no outcome pulse is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_kind | input | 2 | Erase kind: 0 page, 1 block, 2 sector, 3 whole device |
| req_addr | input | 24 | Device-format start address |
| req_len | input | 24 | Length in bytes, used only for the checks |
| req_ready | output | 1 | Idle; a request is taken when both ready and valid are high |
| spi_sel | output | 1 | Chip select, active high, spans each frame |
| spi_go | output | 1 | Byte transfer request to the shifter |
| spi_txd | output | 8 | Byte to send |
| spi_done | input | 1 | Single-cycle byte completion from the shifter |
| spi_rxd | input | 8 | Byte received, valid with `spi_done` |
| erase_done | output | 1 | Pulse: device reported ready |
| erase_timeout | output | 1 | Pulse: retry budget used up |
| erase_reject | output | 1 | Pulse: request refused, nothing sent |

## Verification
The bench builds the block with `TICK_CYCLES = 2`, `PAGE_BYTES = 256` and `CAP_BYTES = 65536`. With these values, a sector wait is 4000 cycles and a whole-device wait is 10000 cycles, so the intervals of all four kinds can be measured exactly. The full page and block retry budgets also fit, which lets the bench reach both a timeout and a success at the very last permitted read. The small capacity puts the exact-end and one-past-end bounds cases at addresses that are easy to hit, and a device model answers busy with all other status bits set, to show that only bit 7 matters.

// File: rtl/erase_seq_pkg.sv
// Shared types and protocol constants for the erase sequencer.
// Assumes a 24-bit device address carried in a fixed four-byte frame.
package erase_seq_pkg;

    localparam int FRAME_ADDR_W = 24;
    localparam int FRAME_BYTES  = 4;
    localparam int IDX_W        = $clog2(FRAME_BYTES);
    localparam int UNITS_W      = 13;   // wait interval in 100 us units
    localparam int RETRY_W      = 9;    // retry budget counter

    localparam logic [7:0]              OP_READ_STATUS = 8'hD7;
    localparam logic [7:0]              POLL_DUMMY     = 8'h00;
    localparam logic [FRAME_ADDR_W-1:0] WHOLE_DEV_KEY  = 24'h94809A;

    typedef enum logic [1:0] {
        KIND_PAGE   = 2'd0,
        KIND_BLOCK  = 2'd1,
        KIND_SECTOR = 2'd2,
        KIND_WHOLE  = 2'd3
    } erase_kind_e;

    typedef struct packed {
        logic [7:0]         opcode;
        logic [UNITS_W-1:0] wait_units;
        logic [RETRY_W-1:0] retries;
    } erase_profile_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_WAIT,
        ST_OK,
        ST_FAIL,
        ST_REJ
    } seq_state_e;

endpackage

// File: rtl/erase_profile_lut.sv
// Per-kind erase profile: opcode, poll interval (100 us units), retry budget.
// Purely combinational; assumes a legal 2-bit kind code.
module erase_profile_lut
    import erase_seq_pkg::*;
(
    input  erase_kind_e    kind,
    output erase_profile_t prof
);

    // Select the profile belonging to the requested erase kind.
    always_comb begin
        unique case (kind)
            KIND_PAGE:   prof = '{opcode: 8'h81, wait_units: UNITS_W'(5),    retries: RETRY_W'(200)};
            KIND_BLOCK:  prof = '{opcode: 8'h50, wait_units: UNITS_W'(10),   retries: RETRY_W'(300)};
            KIND_SECTOR: prof = '{opcode: 8'h7C, wait_units: UNITS_W'(2000), retries: RETRY_W'(100)};
            default:     prof = '{opcode: 8'hC7, wait_units: UNITS_W'(5000), retries: RETRY_W'(200)};
        endcase
    end

endmodule

// File: rtl/erase_req_check.sv
// Request screening: page alignment of address and length (all kinds except
// whole-device) and end-of-range against the device capacity (all kinds).
// Assumes PAGE_BYTES is a power of two.
module erase_req_check
    import erase_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int CAP_BYTES  = 131072
) (
    input  erase_kind_e             kind,
    input  logic [FRAME_ADDR_W-1:0] addr,
    input  logic [FRAME_ADDR_W-1:0] len,
    output logic                    accept
);

    localparam int                PG_LSB = $clog2(PAGE_BYTES);
    localparam logic [FRAME_ADDR_W:0] CAP_V = (FRAME_ADDR_W+1)'(CAP_BYTES);

    logic                  aligned;
    logic [FRAME_ADDR_W:0] end_sum;
    logic                  in_range;

    // Alignment test; a one-byte page makes every request aligned.
    generate
        if (PG_LSB == 0) begin : g_no_align
            assign aligned = 1'b1;
        end else begin : g_align
            assign aligned = (addr[PG_LSB-1:0] == '0) && (len[PG_LSB-1:0] == '0);
        end
    endgenerate

    // End-of-range test with one extra bit so the sum cannot wrap.
    always_comb begin
        end_sum  = {1'b0, addr} + {1'b0, len};
        in_range = (end_sum <= CAP_V);
    end

    // Combine: whole-device erase needs only the range test.
    always_comb begin
        accept = in_range && (aligned || (kind == KIND_WHOLE));
    end

endmodule

// File: rtl/erase_poll_timer.sv
// Poll interval timer. A load sets the count to units*TICK_CYCLES-1; it then
// counts down to zero and rests there. Assumes units*TICK_CYCLES >= 1.
module erase_poll_timer
    import erase_seq_pkg::*;
#(
    parameter int TICK_CYCLES = 10000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [UNITS_W-1:0] units,
    output logic               expired
);

    localparam longint MAX_CYC = longint'((2**UNITS_W) - 1) * longint'(TICK_CYCLES);
    localparam int     CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Interval length in cycles, minus one for the terminal zero cycle.
    always_comb begin
        load_val = CNT_W'(units) * CNT_W'(TICK_CYCLES) - CNT_W'(1);
    end

    // Down-counter with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R6: the count falls by exactly one per cycle when not reloaded.
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/flash_erase_seq.sv
// Erase sequencer top. Screens a request, sends the four-byte erase frame,
// then polls the status register with per-kind interval and retry budget.
// Assumes the byte shifter holds spi_done for one cycle per byte.
module flash_erase_seq
    import erase_seq_pkg::*;
#(
    parameter int PAGE_BYTES  = 256,
    parameter int CAP_BYTES   = 131072,
    parameter int TICK_CYCLES = 10000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [1:0]              req_kind,
    input  logic [FRAME_ADDR_W-1:0] req_addr,
    input  logic [FRAME_ADDR_W-1:0] req_len,
    output logic                    req_ready,
    output logic                    spi_sel,
    output logic                    spi_go,
    output logic [7:0]              spi_txd,
    input  logic                    spi_done,
    input  logic [7:0]              spi_rxd,
    output logic                    erase_done,
    output logic                    erase_timeout,
    output logic                    erase_reject
);

    seq_state_e              state_q;
    erase_profile_t          prof_in;
    erase_profile_t          prof_q;
    logic [FRAME_ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]        idx_q;
    logic [RETRY_W-1:0]      retry_q;
    logic                    req_ok;
    logic                    take_req;
    logic                    dev_ready;
    logic                    wait_start;
    logic                    tmr_expired;
    logic [7:0]              frame_b [FRAME_BYTES];

    erase_profile_lut u_prof (
        .kind (erase_kind_e'(req_kind)),
        .prof (prof_in)
    );

    erase_req_check #(
        .PAGE_BYTES (PAGE_BYTES),
        .CAP_BYTES  (CAP_BYTES)
    ) u_check (
        .kind   (erase_kind_e'(req_kind)),
        .addr   (req_addr),
        .len    (req_len),
        .accept (req_ok)
    );

    erase_poll_timer #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wait_start),
        .units   (prof_q.wait_units),
        .expired (tmr_expired)
    );

    // Frame byte 0 is the opcode; the rest are the address, high byte first.
    assign frame_b[0] = prof_q.opcode;
    generate
        for (genvar gi = 1; gi < FRAME_BYTES; gi++) begin : g_frame
            assign frame_b[gi] = addr_q[(FRAME_BYTES-1-gi)*8 +: 8];
        end
    endgenerate

    // Handshake and decision strobes.
    always_comb begin
        take_req   = (state_q == ST_IDLE) && req_valid;
        dev_ready  = spi_rxd[7];
        wait_start = (state_q == ST_POLL_RD) && spi_done && !dev_ready && (retry_q != '0);
    end

    // Sequencer state, latched request and retry budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prof_q  <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
            retry_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take_req) begin
                        if (req_ok) begin
                            state_q <= ST_CMD;
                            prof_q  <= prof_in;
                            addr_q  <= (erase_kind_e'(req_kind) == KIND_WHOLE) ? WHOLE_DEV_KEY : req_addr;
                            idx_q   <= '0;
                            retry_q <= prof_in.retries;
                        end else begin
                            state_q <= ST_REJ;
                        end
                    end
                end
                ST_CMD: begin
                    if (spi_done) begin
                        if (idx_q == IDX_W'(FRAME_BYTES - 1)) begin
                            state_q <= ST_GAP;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_GAP:     state_q <= ST_POLL_OP;
                ST_POLL_OP: if (spi_done) state_q <= ST_POLL_RD;
                ST_POLL_RD: begin
                    if (spi_done) begin
                        if (dev_ready) begin
                            state_q <= ST_OK;
                        end else if (retry_q == '0) begin
                            state_q <= ST_FAIL;
                        end else begin
                            retry_q <= retry_q - RETRY_W'(1);
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: if (tmr_expired) state_q <= ST_POLL_OP;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state register.
    always_comb begin
        spi_sel       = (state_q == ST_CMD) || (state_q == ST_POLL_OP) || (state_q == ST_POLL_RD);
        spi_go        = spi_sel;
        req_ready     = (state_q == ST_IDLE);
        erase_done    = (state_q == ST_OK);
        erase_timeout = (state_q == ST_FAIL);
        erase_reject  = (state_q == ST_REJ);
        unique case (state_q)
            ST_CMD:     spi_txd = frame_b[idx_q];
            ST_POLL_OP: spi_txd = OP_READ_STATUS;
            default:    spi_txd = POLL_DUMMY;
        endcase
    end

    // R4: a byte request only ever occurs inside a select period.
    p_go_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |-> spi_sel);

    // R2: the outgoing byte holds while its transfer is pending.
    p_hold_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_go && !spi_done) |=> (spi_go && $stable(spi_txd)));

    // R10: at most one outcome pulse at a time.
    p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_done, erase_timeout, erase_reject}));

    // R10: each outcome pulse lasts one cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> !erase_done);

    // R4: completion follows a finished byte that reported ready.
    p_done_on_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> ($past(spi_done) && $past(spi_rxd[7])));

    // R7: timeout follows a finished byte that reported busy.
    p_timeout_on_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_timeout |-> ($past(spi_done) && !$past(spi_rxd[7])));

    // R8: a rejection comes with no select activity.
    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_reject |-> (!spi_sel && !$past(spi_sel)));

endmodule

// File: tb/flash_erase_seq_tb.sv
// Bench: behavioural byte-shifter/device model, per-clock protocol monitor,
// and per-operation comparison against values derived from the requirements.
module flash_erase_seq_tb;

    localparam int PAGE  = 256;
    localparam int CAP   = 65536;
    localparam int TICK  = 2;
    localparam int LAT   = 2;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [23:0] req_addr = '0;
    logic [23:0] req_len = '0;
    logic        req_ready;
    logic        spi_sel, spi_go;
    logic [7:0]  spi_txd;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rxd = 8'h00;
    logic        erase_done, erase_timeout, erase_reject;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit awaiting = 0;

    // Device model state
    int   ready_at = 0;
    int   frame_id = 0;
    int   byte_in_frame = 0;
    int   poll_seen = 0;
    bit   cur_ready = 0;
    bit   sel_prev = 0;
    bit   busy = 0;
    int   lat_cnt = 0;
    logic [7:0] byte_q[$];
    int   frm_q[$];
    int   gap_q[$];
    int   low_run = 0;

    always #2 clk = ~clk;   // 250 MHz

    flash_erase_seq #(
        .PAGE_BYTES  (PAGE),
        .CAP_BYTES   (CAP),
        .TICK_CYCLES (TICK)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_addr      (req_addr),
        .req_len       (req_len),
        .req_ready     (req_ready),
        .spi_sel       (spi_sel),
        .spi_go        (spi_go),
        .spi_txd       (spi_txd),
        .spi_done      (spi_done),
        .spi_rxd       (spi_rxd),
        .erase_done    (erase_done),
        .erase_timeout (erase_timeout),
        .erase_reject  (erase_reject)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Byte shifter and flash status model
    always @(posedge clk) begin
        if (spi_sel && !sel_prev) begin
            frame_id      = frame_id + 1;
            byte_in_frame = 0;
        end
        sel_prev = spi_sel;
        if (spi_done) begin
            spi_done <= 1'b0;
        end else if (busy) begin
            lat_cnt = lat_cnt - 1;
            if (lat_cnt == 0) begin
                busy = 0;
                spi_done <= 1'b1;
                spi_rxd  <= cur_ready ? 8'h80 : 8'h7F;
            end
        end else if (spi_go) begin
            if (byte_in_frame == 0 && spi_txd == 8'hD7) begin
                cur_ready = (poll_seen >= ready_at);
                poll_seen = poll_seen + 1;
            end
            byte_q.push_back(spi_txd);
            frm_q.push_back(frame_id);
            byte_in_frame = byte_in_frame + 1;
            busy    = 1;
            lat_cnt = LAT;
        end
    end

    // Per-clock monitor: protocol rules and unexpected outcomes
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(!spi_go || spi_sel, "R4 go outside select", spi_go, 0);
            check($countones({erase_done, erase_timeout, erase_reject}) <= 1,
                  "R10 outcome onehot", {erase_done, erase_timeout, erase_reject}, 0);
            if (!awaiting)
                check(!(erase_done || erase_timeout || erase_reject), "R10 stray outcome",
                      {erase_done, erase_timeout, erase_reject}, 0);
            if (!spi_sel && frame_id > 0) begin
                low_run++;
            end else if (spi_sel && low_run > 0) begin
                gap_q.push_back(low_run);
                low_run = 0;
            end
        end
        if (cycles > LIMIT) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [7:0] kind_op(input int k);   // R1 table
        case (k)
            0: return 8'h81;
            1: return 8'h50;
            2: return 8'h7C;
            default: return 8'hC7;
        endcase
    endfunction

    function automatic int kind_budget(input int k);       // R7 table
        case (k)
            0: return 200;
            1: return 300;
            2: return 100;
            default: return 200;
        endcase
    endfunction

    function automatic int kind_units(input int k);        // R6 table
        case (k)
            0: return 5;
            1: return 10;
            2: return 2000;
            default: return 5000;
        endcase
    endfunction

    // outcome: 0 done, 1 timeout, 2 reject
    task automatic run_op(input int k, input int a, input int l, input int rdy, input int exp_out,
                          input string tag);
        int got;
        int polls;
        int guard;
        logic [23:0] ea;
        byte_q.delete(); frm_q.delete(); gap_q.delete();
        frame_id = 0; poll_seen = 0; low_run = 0; ready_at = rdy;
        @(negedge clk);
        check(req_ready == 1'b1, {tag, " R10 ready when idle"}, req_ready, 1);
        awaiting  = 1;
        req_valid = 1'b1;
        req_kind  = 2'(k);
        req_addr  = 24'(a);
        req_len   = 24'(l);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, {tag, " R10 busy after accept"}, req_ready, 0);
        got = -1;
        guard = 0;
        while (got < 0 && guard < 60000) begin
            if (erase_done) got = 0;
            else if (erase_timeout) got = 1;
            else if (erase_reject) got = 2;
            else begin
                @(negedge clk);
                guard++;
            end
        end
        check(got == exp_out, {tag, " outcome"}, got, exp_out);
        @(negedge clk);
        awaiting = 0;
        check(req_ready && !erase_done && !erase_timeout && !erase_reject,
              {tag, " R10 single pulse then idle"}, req_ready, 1);
        if (exp_out == 2) begin
            check(byte_q.size() == 0 && frame_id == 0, {tag, " R8 R9 no traffic"}, byte_q.size(), 0);
            return;
        end
        polls = (exp_out == 0) ? rdy + 1 : kind_budget(k) + 1;
        check(byte_q.size() == 4 + 2 * polls, {tag, " R4 R7 byte count"}, byte_q.size(), 4 + 2 * polls);
        if (byte_q.size() != 4 + 2 * polls) return;
        ea = (k == 3) ? 24'h94809A : 24'(a);
        check(byte_q[0] == kind_op(k), {tag, " R1 opcode"}, byte_q[0], kind_op(k));
        check(byte_q[1] == ea[23:16] && byte_q[2] == ea[15:8] && byte_q[3] == ea[7:0],
              {tag, " R2 R3 address bytes"}, {byte_q[1], byte_q[2], byte_q[3]}, ea);
        check(frm_q[0] == 1 && frm_q[3] == 1, {tag, " R2 one frame"}, frm_q[3], 1);
        for (int i = 0; i < polls; i++) begin
            check(byte_q[4 + 2*i] == 8'hD7 && byte_q[5 + 2*i] == 8'h00 &&
                  frm_q[4 + 2*i] == i + 2 && frm_q[5 + 2*i] == i + 2,
                  {tag, " R4 poll frame"}, {byte_q[4 + 2*i], byte_q[5 + 2*i]}, 16'hD700);
        end
        check(gap_q.size() == polls, {tag, " R5 R6 gap count"}, gap_q.size(), polls);
        if (gap_q.size() == polls) begin
            check(gap_q[0] == 1, {tag, " R4 R5 gap after command"}, gap_q[0], 1);
            for (int i = 1; i < polls; i++)
                check(gap_q[i] == kind_units(k) * TICK, {tag, " R6 interval"}, gap_q[i],
                      kind_units(k) * TICK);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!spi_sel && !spi_go, "R11 select idle in reset", {spi_sel, spi_go}, 0);
        check(req_ready == 1'b1, "R11 ready in reset", req_ready, 1);
        check(!erase_done && !erase_timeout && !erase_reject, "R11 no outcome in reset",
              {erase_done, erase_timeout, erase_reject}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(0, 24'h000100, 256,     0,    0, "page ready at once R5");
        run_op(1, 24'h000800, 2048,    3,    0, "block 4 polls R6");
        run_op(2, 24'h008000, 24'h8000, 2,   0, "sector 3 polls R6");
        run_op(3, 24'h000000, CAP,     1,    0, "whole device R3");
        run_op(0, 24'h001000, 512,     1000, 1, "page timeout R7");
        run_op(1, 24'h002000, 2048,    300,  0, "block ready at last poll R7");
        run_op(0, 24'h000110, 256,     0,    2, "page bad address R8");
        run_op(2, 24'h000000, 100,     0,    2, "sector bad length R8");
        run_op(0, 24'h00FF00, 512,     0,    2, "page past end R9");
        run_op(0, 24'h00FF00, 256,     0,    0, "page exact end R9");
        run_op(3, 24'h000010, 24'hFFF0, 0,   0, "whole device unaligned R8 R3");
        run_op(3, 24'h000000, CAP + 1, 0,    2, "whole device past end R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule